// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block is one bank of general-purpose pins, up to sixteen of them. A 32-bit word-addressed register port reaches the bank. Software picks each pin's direction and sets the value the pin drives. It can also read back the live pin levels, which pass through a synchronizer first.

Each pin also has its own event detector. The detector can fire on a falling edge, a rising edge, either edge, a low level or a high level. An event that fires while the pin's enable bit is set latches a status bit. The latched status bits are combined with a per-pin mask into one registered interrupt line. Software clears a status bit by writing a one to it. The mask is set and cleared through two separate write-one registers.

A soft-reset register returns every register of the bank to its default value. The word index of each register is given in the requirements. Reads return data one clock after the read strobe.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, the mask reads 0x0000FFFF (all pins masked), and enable, direction, output latch, status and modes read zero. `irq` and `pin_oe` are low.
- R2: A write to word 1 (direction) sets `pin_oe`, and a write to word 0 (output latch) sets `pin_out`, both at the next clock. Both words read back what was written.
- R3: Word 2 returns the pin levels after a two-flop synchronizer. Bits at or above the pin count read zero.
- R4: The edge codes are 0 (falling), 1 (rising) and 4 (both edges). Each latches status only on its own transition.
- R5: Code 2 latches status on a low level and code 3 on a high level. While the level persists, the status bit sets again after it is cleared.
- R6: Codes 5 to 7 never latch status. Pin p takes its 3-bit code from bits [4(p mod 8)+2 : 4(p mod 8)]: word 9 holds pins 0-7 and word 10 holds pins 8-15.
- R7: A pin whose bit in word 3 (enable) is 0 never latches status.
- R8: Word 4 reads the raw status. Writing ones to word 6 clears those status bits, and zero bits leave status unchanged. An event in the same cycle as a clear leaves the bit set.
- R9: Writing ones to word 7 masks those pins and writing ones to word 8 unmasks them. Zero bits change nothing, and both words read the mask.
- R10: Word 5 reads status AND NOT mask. `irq` is high exactly when that vector is non-zero, delayed by one clock.
- R11: Writing 1 and then 0 to bit 0 of word 11 returns all other registers to their R1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_idx | input | IDX_W (4) | Word index of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, valid one clock after `bus_rd` |
| pin_in | input | PINS (16) | Asynchronous pin levels |
| pin_out | output | PINS (16) | Output latch value |
| pin_oe | output | PINS (16) | Per-pin output enable (1 = drive) |
| irq | output | 1 | Registered combined interrupt |

## Verification
The hardest situations to reach are a level event arriving in the same cycle as a clear, and an edge that lands while its enable bit is changing. Both depend on pin timing through the synchronizer.

The stimulus settles each pin at its start level before enabling detection. The pin then moves only after the enable write has landed, so every table entry checks exactly one transition.

The collision case uses a pin held at its active level. The clear write then meets a live detection in the same cycle, and the read that follows must still show the bit set.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [2:0] {
    DET_FALL = 3'd0,
    DET_RISE = 3'd1,
    DET_LOW  = 3'd2,
    DET_HIGH = 3'd3,
    DET_BOTH = 3'd4
  } det_mode_e;

  localparam int CODE_W       = 3;
  localparam int NIB_W        = 4;
  localparam int NIB_PER_WORD = 8;

  localparam int IDX_OUT     = 0;
  localparam int IDX_DIR     = 1;
  localparam int IDX_LEVEL   = 2;
  localparam int IDX_IEN     = 3;
  localparam int IDX_RAW     = 4;
  localparam int IDX_PEND    = 5;
  localparam int IDX_ACK     = 6;
  localparam int IDX_MSET    = 7;
  localparam int IDX_MCLR    = 8;
  localparam int IDX_MODE_LO = 9;
  localparam int IDX_MODE_HI = 10;
  localparam int IDX_SRST    = 11;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
  import gpio_bank_pkg::*;
#(
  parameter int PINS = 16
) (
  input  logic                   clk,
  input  logic [PINS-1:0]        lvl,
  input  logic [PINS*CODE_W-1:0] mode_vec,
  input  logic [PINS-1:0]        ien,
  output logic [PINS-1:0]        evt
);
  logic [PINS-1:0] prev_q;

  always_ff @(posedge clk) prev_q <= lvl;

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic [CODE_W-1:0] code;
    logic              hit;
    assign code = mode_vec[p*CODE_W +: CODE_W];
    always_comb begin
      case (code)
        DET_FALL: hit = prev_q[p] & ~lvl[p];
        DET_RISE: hit = ~prev_q[p] & lvl[p];
        DET_LOW:  hit = ~lvl[p];
        DET_HIGH: hit = lvl[p];
        DET_BOTH: hit = prev_q[p] ^ lvl[p];
        default:  hit = 1'b0;
      endcase
    end
    assign evt[p] = hit & ien[p];
  end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int PINS = 16
) (
  input  logic            clk,
  input  logic            clr,
  input  logic [PINS-1:0] evt,
  input  logic            ack_we,
  input  logic [PINS-1:0] ack_bits,
  input  logic            mset_we,
  input  logic [PINS-1:0] mset_bits,
  input  logic            mclr_we,
  input  logic [PINS-1:0] mclr_bits,
  output logic [PINS-1:0] stat,
  output logic [PINS-1:0] mask,
  output logic            irq
);
  logic [PINS-1:0] ack_eff, set_eff, unset_eff;

  assign ack_eff   = ack_we  ? ack_bits  : '0;
  assign set_eff   = mset_we ? mset_bits : '0;
  assign unset_eff = mclr_we ? mclr_bits : '0;

  always_ff @(posedge clk) begin
    if (clr) begin
      stat <= '0;
      mask <= '1;
      irq  <= 1'b0;
    end else begin
      stat <= (stat & ~ack_eff) | evt;
      mask <= (mask & ~unset_eff) | set_eff;
      irq  <= |(stat & ~mask);
    end
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int PINS        = 16,
  parameter int DW          = 32,
  parameter int IDX_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [IDX_W-1:0] bus_idx,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [PINS-1:0]  pin_in,
  output logic [PINS-1:0]  pin_out,
  output logic [PINS-1:0]  pin_oe,
  output logic             irq
);
  localparam int MODE_BITS = PINS * CODE_W;

  logic [PINS-1:0]      out_q, dir_q, ien_q;
  logic                 srst_q;
  logic                 clr_all;
  logic [PINS-1:0]      lvl_s, evt, stat_w, mask_w;
  logic [MODE_BITS-1:0] mode_vec;
  logic [DW-1:0]        mode_lo, mode_hi;
  logic                 unused_wdata;

  assign clr_all      = rst | srst_q;
  assign unused_wdata = ^bus_wdata;

  function automatic logic hit_idx(input logic [IDX_W-1:0] idx, input int k);
    return idx == IDX_W'(k);
  endfunction

  always_ff @(posedge clk) begin
    if (rst)                                       srst_q <= 1'b0;
    else if (bus_wr && hit_idx(bus_idx, IDX_SRST)) srst_q <= bus_wdata[0];
  end

  always_ff @(posedge clk) begin
    if (clr_all) begin
      out_q <= '0;
      dir_q <= '0;
      ien_q <= '0;
    end else if (bus_wr) begin
      if (hit_idx(bus_idx, IDX_OUT)) out_q <= bus_wdata[PINS-1:0];
      if (hit_idx(bus_idx, IDX_DIR)) dir_q <= bus_wdata[PINS-1:0];
      if (hit_idx(bus_idx, IDX_IEN)) ien_q <= bus_wdata[PINS-1:0];
    end
  end

  for (genvar p = 0; p < PINS; p++) begin : g_mode
    localparam int LANE = (p % NIB_PER_WORD) * NIB_W;
    localparam int WIDX = (p < NIB_PER_WORD) ? IDX_MODE_LO : IDX_MODE_HI;
    logic [CODE_W-1:0] code_q;
    always_ff @(posedge clk) begin
      if (clr_all)                               code_q <= '0;
      else if (bus_wr && hit_idx(bus_idx, WIDX)) code_q <= bus_wdata[LANE +: CODE_W];
    end
    assign mode_vec[p*CODE_W +: CODE_W] = code_q;
  end

  always_comb begin
    mode_lo = '0;
    mode_hi = '0;
    for (int p = 0; p < PINS; p++) begin
      if (p < NIB_PER_WORD)
        mode_lo[(p % NIB_PER_WORD)*NIB_W +: CODE_W] = mode_vec[p*CODE_W +: CODE_W];
      else
        mode_hi[(p % NIB_PER_WORD)*NIB_W +: CODE_W] = mode_vec[p*CODE_W +: CODE_W];
    end
  end

  gpio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(lvl_s)
  );

  gpio_pin_detect #(.PINS(PINS)) u_detect (
    .clk(clk), .lvl(lvl_s), .mode_vec(mode_vec), .ien(ien_q), .evt(evt)
  );

  gpio_irq_status #(.PINS(PINS)) u_status (
    .clk(clk), .clr(clr_all), .evt(evt),
    .ack_we(bus_wr && hit_idx(bus_idx, IDX_ACK)),   .ack_bits(bus_wdata[PINS-1:0]),
    .mset_we(bus_wr && hit_idx(bus_idx, IDX_MSET)), .mset_bits(bus_wdata[PINS-1:0]),
    .mclr_we(bus_wr && hit_idx(bus_idx, IDX_MCLR)), .mclr_bits(bus_wdata[PINS-1:0]),
    .stat(stat_w), .mask(mask_w), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_idx)
        IDX_W'(IDX_OUT):     bus_rdata <= DW'(out_q);
        IDX_W'(IDX_DIR):     bus_rdata <= DW'(dir_q);
        IDX_W'(IDX_LEVEL):   bus_rdata <= DW'(lvl_s);
        IDX_W'(IDX_IEN):     bus_rdata <= DW'(ien_q);
        IDX_W'(IDX_RAW):     bus_rdata <= DW'(stat_w);
        IDX_W'(IDX_PEND):    bus_rdata <= DW'(stat_w & ~mask_w);
        IDX_W'(IDX_MSET),
        IDX_W'(IDX_MCLR):    bus_rdata <= DW'(mask_w);
        IDX_W'(IDX_MODE_LO): bus_rdata <= mode_lo;
        IDX_W'(IDX_MODE_HI): bus_rdata <= mode_hi;
        IDX_W'(IDX_SRST):    bus_rdata <= DW'(srst_q);
        default:             bus_rdata <= '0;
      endcase
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int PINS  = 16,
  parameter int DW    = 32,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_wr,
  input logic [IDX_W-1:0] bus_idx,
  input logic [DW-1:0]    bus_wdata,
  input logic [PINS-1:0]  pin_oe,
  input logic             irq,
  input logic [PINS-1:0]  stat_w,
  input logic [PINS-1:0]  mask_w,
  input logic [PINS-1:0]  ien_q,
  input logic             srst_q
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && pin_oe == '0 && mask_w == '1));

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_idx == IDX_W'(1) && !srst_q) |=> pin_oe == $past(bus_wdata[PINS-1:0]));

  // R7
  enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_w & ~$past(stat_w) & ~$past(ien_q)) == '0);

  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (&$past(mask_w)) |-> !irq);

  // R11
  soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(srst_q) |-> (stat_w == '0 && mask_w == '1 && pin_oe == '0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.PINS(PINS), .DW(DW), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_idx(bus_idx), .bus_wdata(bus_wdata),
  .pin_oe(pin_oe), .irq(irq), .stat_w(stat_w), .mask_w(mask_w), .ien_q(ien_q),
  .srst_q(srst_q)
);

// File: tb/gpio_irq_bank_bench.sv
`timescale 1ns/1ps
module gpio_irq_bank_bench;
  localparam int PINS = 16;
  localparam int NVEC = 12;
  // entry: {code[2:0], start level, end level, expected status}
  localparam logic [5:0] VEC [NVEC] = '{
    {3'd0, 1'b1, 1'b0, 1'b1}, {3'd0, 1'b0, 1'b1, 1'b0},
    {3'd1, 1'b0, 1'b1, 1'b1}, {3'd1, 1'b1, 1'b0, 1'b0},
    {3'd4, 1'b0, 1'b1, 1'b1}, {3'd4, 1'b1, 1'b0, 1'b1},
    {3'd2, 1'b1, 1'b0, 1'b1}, {3'd2, 1'b1, 1'b1, 1'b0},
    {3'd3, 1'b0, 1'b1, 1'b1}, {3'd3, 1'b0, 1'b0, 1'b0},
    {3'd5, 1'b0, 1'b1, 1'b0}, {3'd7, 1'b1, 1'b0, 1'b0}
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]      bus_idx = '0;
  logic [31:0]     bus_wdata = '0, bus_rdata;
  logic [PINS-1:0] pin_in = '0, pin_out, pin_oe;
  logic            irq;
  int              total = 0, bad = 0;

  always #2 clk = ~clk;

  gpio_irq_bank u_gpio_irq_bank (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_idx(bus_idx),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_idx = 4'(idx); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_idx = 4'(idx);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    idle(4);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    rd(7, r);  check("R1 mask", r, 32'h0000FFFF);
    rd(3, r);  check("R1 enable", r, 0);
    rd(4, r);  check("R1 status", r, 0);
    rd(9, r);  check("R1 mode", r, 0);
    check("R1 irq/oe", {15'd0, irq, pin_oe}, 0);

    // R2 direction and output latch
    wr(1, 32'h000000A5); wr(0, 32'h000000FF);
    check("R2 pin_oe", 32'(pin_oe), 32'hA5);
    check("R2 pin_out", 32'(pin_out), 32'hFF);
    rd(1, r); check("R2 dir readback", r, 32'hA5);
    rd(0, r); check("R2 out readback", r, 32'hFF);

    // R3 synchronized input, upper bits zero
    pin_in = 16'h3C5A; idle(3);
    rd(2, r); check("R3 level", r, 32'h00003C5A);
    pin_in = '0; idle(3);

    // R4 R5 R6 table of detector modes, pin = entry index
    for (int i = 0; i < NVEC; i++) begin
      logic [2:0] code;
      string tag;
      code = VEC[i][5:3];
      tag = (code == 3'd2 || code == 3'd3) ? "R5" : (code > 3'd4) ? "R6" : "R4";
      wr(3, 0);
      wr(6, 32'hFFFFFFFF);
      wr(9, {8{1'b0, code}});
      wr(10, {8{1'b0, code}});
      pin_in[i] = VEC[i][2];
      idle(6);
      wr(3, 32'(1) << i);
      pin_in[i] = VEC[i][1];
      idle(6);
      rd(4, r);
      check(tag, r, 32'(VEC[i][0]) << i);
    end
    wr(3, 0); pin_in = '0; idle(4); wr(6, 32'hFFFFFFFF);

    // R5 persistence and R8 collision: high level on pin 12
    wr(10, 32'h33333333);
    pin_in[12] = 1'b1; idle(3);
    wr(3, 32'h1000); idle(2);
    wr(6, 32'h1000);
    rd(4, r); check("R5 R8 level re-sets after clear", r, 32'h1000);
    pin_in[12] = 1'b0; idle(4);
    wr(6, 32'h1000);
    rd(4, r); check("R5 cleared after level gone", r, 0);

    // R8 clear with zero bit leaves status
    wr(3, 0); wr(9, 32'h11111111);
    wr(3, 32'h2); pin_in[1] = 1'b1; idle(4);
    wr(6, 32'hFFFFFFFD);
    rd(4, r); check("R8 zero bit keeps", r, 32'h2);
    wr(6, 32'h2);
    rd(4, r); check("R8 one bit clears", r, 0);

    // R7 disabled pin ignores rising edge
    wr(3, 0); pin_in[2] = 1'b1; idle(5);
    rd(4, r); check("R7 disabled", r, 0);

    // R9 R10 mask and irq
    wr(3, 32'h8); pin_in[3] = 1'b1; idle(5);
    rd(4, r); check("R9 raw set", r, 32'h8);
    check("R9 masked irq low", 32'(irq), 0);
    wr(8, 32'h0); idle(2);
    check("R9 zero unmask no effect", 32'(irq), 0);
    wr(8, 32'h8); idle(2);
    check("R10 irq high", 32'(irq), 1);
    rd(5, r); check("R10 pending", r, 32'h8);
    rd(8, r); check("R9 mask read", r, 32'hFFF7);
    wr(7, 32'h0); idle(2);
    check("R9 zero set no effect", 32'(irq), 1);
    wr(7, 32'h8); idle(2);
    check("R10 irq low when masked", 32'(irq), 0);

    // R11 soft reset
    wr(1, 32'hF0F0); wr(0, 32'h1234); wr(8, 32'hFFFF);
    wr(11, 1); wr(11, 0);
    rd(1, r); check("R11 dir", r, 0);
    rd(7, r); check("R11 mask", r, 32'hFFFF);
    rd(4, r); check("R11 status", r, 0);
    rd(10, r); check("R11 mode", r, 0);
    check("R11 pins", {pin_out, pin_oe}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule